// File: doc/BRIEF.md
# Scan-Line Block Transfer Sequencer

This block steers a rectangular block transfer through a 2D drawing datapath one scan line at a time. Software first programs the geometry registers: line width in bytes, number of lines, and a start address and line stride for both the source and the destination. It then writes the mode register, and that write starts the transfer. The mode picks where each operand comes from. An operand can be absent, fetched from the frame buffer, or held in a local line buffer. The mode also carries a source-expansion flag, which the block hands to the external combine stage.

For each line the sequencer fetches the frame-buffer operands into two external line buffers (source and destination). It then reads the buffers byte by byte. For every byte it takes the result from the external combine stage and writes it to the destination line in the frame buffer. A source kept in the local buffer is a bitmap. The bitmap is fetched in full, once, before the first line, and each line then indexes into it. Buffer capacity is not checked. A transfer larger than the buffer is undefined.

Top module: `blit_line_seq`

## Requirements
- R1: After reset, busy, fb_req_valid, buf_we and buf_re are all low.
- R2: Registers are written through reg_we/reg_addr/reg_wdata. Address 1 holds the width, 2 the height, 3 the source base, 4 the source stride, 5 the destination base, 6 the destination stride. Writing address 0 (mode) starts a transfer, and busy is high by the third rising edge after the write cycle.
- R3: Mode bits [1:0] select the source kind and bits [3:2] the destination kind, with 0 = absent, 1 = frame buffer, 2 = local buffer and 3 = absent. Bit 4 is the expansion flag. rop_expand follows bit 4, and rop_src_en / rop_dst_en are high exactly when the matching kind is 1 or 2.
- R4: With a frame-buffer source, each line starts with width read beats at source base + line × source stride + x, for x from 0 upward. Each response is stored in the source buffer (buf_wsel = 0) at index x.
- R5: With a frame-buffer destination, width read beats at destination base + line × destination stride + x follow the source load of each line. Each response is stored in the destination buffer (buf_wsel = 1) at index x.
- R6: With a local-buffer source, width × height read beats at source base + k, for k = 0, 1, …, are issued once before the first line and stored at source buffer index k. No per-line source reads are made, and line y reads source buffer index y × width + x.
- R7: Each line ends with width write beats to destination base + line × destination stride + x, in increasing x. Each beat carries the rop_result for byte x. No request of any kind is made outside this order.
- R8: While fb_req_valid is high and fb_req_ready is low, the request stays valid and its address, direction and data do not change.
- R9: busy falls no more than three cycles after the last write beat of the last line is accepted, and every expected beat has been issued by then.
- R10: Register writes, including mode writes, are ignored while a transfer is running or starting.
- R11: A mode write with width or height zero makes no request, and busy stays low.
- R12: An absent operand is never fetched, and its enable to the combine stage is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| fb_req_valid | output | 1 | Frame-buffer request valid |
| fb_req_ready | input | 1 | Frame-buffer request accepted |
| fb_req_we | output | 1 | Request is a write (1) or read (0) |
| fb_req_addr | output | AW | Byte address of the request |
| fb_req_wdata | output | DW | Write data |
| fb_rsp_valid | input | 1 | Read response valid, in request order |
| fb_rsp_data | input | DW | Read response data |
| buf_we | output | 1 | Line buffer write strobe |
| buf_wsel | output | 1 | Buffer written: 0 source, 1 destination |
| buf_waddr | output | BUF_AW | Line buffer write index |
| buf_wdata | output | DW | Line buffer write data |
| buf_re | output | 1 | Line buffer read strobe (data one cycle later) |
| buf_src_raddr | output | BUF_AW | Source buffer read index |
| buf_dst_raddr | output | BUF_AW | Destination buffer read index |
| rop_expand | output | 1 | Source-expansion flag to the combine stage |
| rop_src_en | output | 1 | Source operand present |
| rop_dst_en | output | 1 | Destination operand present |
| rop_result | input | DW | Combined byte from the combine stage |

## Verification
The hardest case to reach is a register write that lands while a transfer is already in flight. If such a write were taken, it would silently change the geometry or restart the sequence, and the result could still look plausible. The stimulus issues a width write and a second mode write as soon as busy rises. The scoreboard, loaded only with the beats of the original geometry, then flags any extra or shifted beat. Random back-pressure on fb_req_ready also holds request beats across many stall cycles, including the last write of a line. This exercises the hold rule and the line-to-line handover under stalls.

// File: rtl/blit_pkg.sv
`timescale 1ns/1ps
package blit_pkg;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_FB   = 2'd1,
    OPK_BUF  = 2'd2,
    OPK_RSVD = 2'd3
  } opnd_kind_e;

  // Field positions are decoded by the sequencer: [4] expand, [3:2] dst, [1:0] src.
  typedef struct packed {
    logic       expand;
    opnd_kind_e dst;
    opnd_kind_e src;
  } blit_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BITMAP,
    ST_LOAD_SRC,
    ST_LOAD_DST,
    ST_COMBINE,
    ST_NEXT_LINE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_ISSUE,
    PH_READ,
    PH_CAPTURE,
    PH_WAIT
  } cw_phase_e;

  localparam logic [2:0] RA_MODE       = 3'd0;
  localparam logic [2:0] RA_WIDTH      = 3'd1;
  localparam logic [2:0] RA_HEIGHT     = 3'd2;
  localparam logic [2:0] RA_SRC_BASE   = 3'd3;
  localparam logic [2:0] RA_SRC_STRIDE = 3'd4;
  localparam logic [2:0] RA_DST_BASE   = 3'd5;
  localparam logic [2:0] RA_DST_STRIDE = 3'd6;

  function automatic logic kind_used(opnd_kind_e k);
    return (k == OPK_FB) || (k == OPK_BUF);
  endfunction

endpackage

// File: rtl/blit_regs.sv
`timescale 1ns/1ps
module blit_regs
  import blit_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             start,
  output blit_mode_t       mode,
  output logic [LEN_W-1:0] width,
  output logic [LEN_W-1:0] height,
  output logic [AW-1:0]    src_base,
  output logic [AW-1:0]    src_stride,
  output logic [AW-1:0]    dst_base,
  output logic [AW-1:0]    dst_stride
);

  logic take;
  assign take = reg_we && !busy && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      start      <= 1'b0;
      mode       <= '0;
      width      <= '0;
      height     <= '0;
      src_base   <= '0;
      src_stride <= '0;
      dst_base   <= '0;
      dst_stride <= '0;
    end else begin
      start <= 1'b0;
      if (take) begin
        case (reg_addr)
          RA_MODE: begin
            mode  <= blit_mode_t'(reg_wdata[4:0]);
            start <= 1'b1;
          end
          RA_WIDTH:      width      <= LEN_W'(reg_wdata);
          RA_HEIGHT:     height     <= LEN_W'(reg_wdata);
          RA_SRC_BASE:   src_base   <= AW'(reg_wdata);
          RA_SRC_STRIDE: src_stride <= AW'(reg_wdata);
          RA_DST_BASE:   dst_base   <= AW'(reg_wdata);
          RA_DST_STRIDE: dst_stride <= AW'(reg_wdata);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/blit_line_addr.sv
`timescale 1ns/1ps
module blit_line_addr #(
  parameter int AW     = 32,
  parameter int LEN_W  = 16,
  parameter int BUF_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              step,
  input  logic [LEN_W-1:0]  width,
  input  logic [LEN_W-1:0]  height,
  input  logic [AW-1:0]     src_base,
  input  logic [AW-1:0]     src_stride,
  input  logic [AW-1:0]     dst_base,
  input  logic [AW-1:0]     dst_stride,
  output logic [AW-1:0]     src_line,
  output logic [AW-1:0]     dst_line,
  output logic [BUF_AW-1:0] bmp_line,
  output logic              last_line
);

  localparam int NCHAN = 2;

  logic [AW-1:0]    base_v   [NCHAN];
  logic [AW-1:0]    stride_v [NCHAN];
  logic [LEN_W-1:0] line_idx;

  assign base_v[0]   = src_base;
  assign base_v[1]   = dst_base;
  assign stride_v[0] = src_stride;
  assign stride_v[1] = dst_stride;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic [AW-1:0] acc_r;
    always_ff @(posedge clk) begin
      if (rst)       acc_r <= '0;
      else if (init) acc_r <= base_v[c];
      else if (step) acc_r <= acc_r + stride_v[c];
    end
  end

  assign src_line = g_chan[0].acc_r;
  assign dst_line = g_chan[1].acc_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_idx <= '0;
      bmp_line <= '0;
    end else if (init) begin
      line_idx <= '0;
      bmp_line <= '0;
    end else if (step) begin
      line_idx <= line_idx + LEN_W'(1);
      bmp_line <= bmp_line + BUF_AW'(width);
    end
  end

  assign last_line = (line_idx == height - LEN_W'(1));

endmodule

// File: rtl/blit_fsm.sv
`timescale 1ns/1ps
module blit_fsm
  import blit_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 8,
  parameter int LEN_W  = 16,
  parameter int BUF_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  opnd_kind_e        src_kind,
  input  opnd_kind_e        dst_kind,
  input  logic [LEN_W-1:0]  width,
  input  logic [LEN_W-1:0]  height,
  input  logic [AW-1:0]     src_line,
  input  logic [AW-1:0]     dst_line,
  input  logic [BUF_AW-1:0] bmp_line,
  input  logic              last_line,
  input  logic              fb_req_ready,
  input  logic              fb_rsp_valid,
  input  logic [DW-1:0]     fb_rsp_data,
  input  logic [DW-1:0]     rop_result,
  output logic              busy,
  output logic              line_init,
  output logic              line_step,
  output logic              fb_req_valid,
  output logic              fb_req_we,
  output logic [AW-1:0]     fb_req_addr,
  output logic [DW-1:0]     fb_req_wdata,
  output logic              buf_we,
  output logic              buf_wsel,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [DW-1:0]     buf_wdata,
  output logic              buf_re,
  output logic [BUF_AW-1:0] buf_src_raddr,
  output logic [BUF_AW-1:0] buf_dst_raddr
);

  localparam int CNT_W = 2 * LEN_W;

  seq_state_e       state;
  cw_phase_e        ph;
  logic [CNT_W-1:0] issue_cnt;
  logic [CNT_W-1:0] resp_cnt;
  logic [CNT_W-1:0] total;
  logic [LEN_W-1:0] x;
  logic [AW-1:0]    load_base;
  logic             loading;
  logic             load_done;
  logic             dims_ok;
  seq_state_e       after_src_st;
  seq_state_e       line_start_st;

  always_comb begin
    total         = (state == ST_BITMAP) ? CNT_W'(width) * CNT_W'(height) : CNT_W'(width);
    load_base     = (state == ST_LOAD_DST) ? dst_line : src_line;
    loading       = (state == ST_BITMAP) || (state == ST_LOAD_SRC) || (state == ST_LOAD_DST);
    load_done     = loading && (issue_cnt == total) && (resp_cnt == total)
                    && !fb_req_valid && !buf_we;
    dims_ok       = (width != '0) && (height != '0);
    after_src_st  = (dst_kind == OPK_FB) ? ST_LOAD_DST : ST_COMBINE;
    line_start_st = (src_kind == OPK_FB) ? ST_LOAD_SRC : after_src_st;
  end

  assign line_init = (state == ST_IDLE) && start;
  assign line_step = (state == ST_NEXT_LINE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      ph            <= PH_ISSUE;
      busy          <= 1'b0;
      issue_cnt     <= '0;
      resp_cnt      <= '0;
      x             <= '0;
      fb_req_valid  <= 1'b0;
      fb_req_we     <= 1'b0;
      fb_req_addr   <= '0;
      fb_req_wdata  <= '0;
      buf_we        <= 1'b0;
      buf_wsel      <= 1'b0;
      buf_waddr     <= '0;
      buf_wdata     <= '0;
      buf_re        <= 1'b0;
      buf_src_raddr <= '0;
      buf_dst_raddr <= '0;
    end else begin
      buf_we <= 1'b0;
      buf_re <= 1'b0;
      if (fb_rsp_valid) begin
        buf_we    <= 1'b1;
        buf_wsel  <= (state == ST_LOAD_DST);
        buf_waddr <= BUF_AW'(resp_cnt);
        buf_wdata <= fb_rsp_data;
        resp_cnt  <= resp_cnt + CNT_W'(1);
      end
      case (state)
        ST_IDLE: begin
          if (start && dims_ok) begin
            busy  <= 1'b1;
            state <= (src_kind == OPK_BUF) ? ST_BITMAP : line_start_st;
          end
        end
        ST_BITMAP, ST_LOAD_SRC, ST_LOAD_DST: begin
          if (!fb_req_valid || fb_req_ready) begin
            if (issue_cnt < total) begin
              fb_req_valid <= 1'b1;
              fb_req_we    <= 1'b0;
              fb_req_addr  <= load_base + AW'(issue_cnt);
              issue_cnt    <= issue_cnt + CNT_W'(1);
            end else begin
              fb_req_valid <= 1'b0;
            end
          end
          if (load_done) begin
            issue_cnt <= '0;
            resp_cnt  <= '0;
            if (state == ST_LOAD_SRC)      state <= after_src_st;
            else if (state == ST_LOAD_DST) state <= ST_COMBINE;
            else                           state <= line_start_st;
          end
        end
        ST_COMBINE: begin
          case (ph)
            PH_ISSUE: begin
              buf_re        <= 1'b1;
              buf_src_raddr <= (src_kind == OPK_BUF) ? bmp_line + BUF_AW'(x) : BUF_AW'(x);
              buf_dst_raddr <= BUF_AW'(x);
              ph            <= PH_READ;
            end
            PH_READ: ph <= PH_CAPTURE;
            PH_CAPTURE: begin
              fb_req_valid <= 1'b1;
              fb_req_we    <= 1'b1;
              fb_req_addr  <= dst_line + AW'(x);
              fb_req_wdata <= rop_result;
              ph           <= PH_WAIT;
            end
            default: begin
              if (fb_req_ready) begin
                fb_req_valid <= 1'b0;
                ph           <= PH_ISSUE;
                if (x == width - LEN_W'(1)) begin
                  x     <= '0;
                  state <= ST_NEXT_LINE;
                end else begin
                  x <= x + LEN_W'(1);
                end
              end
            end
          endcase
        end
        ST_NEXT_LINE: begin
          if (last_line) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            state <= line_start_st;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blit_line_seq.sv
`timescale 1ns/1ps
module blit_line_seq
  import blit_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 8,
  parameter int LEN_W  = 16,
  parameter int BUF_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              busy,
  output logic              fb_req_valid,
  input  logic              fb_req_ready,
  output logic              fb_req_we,
  output logic [AW-1:0]     fb_req_addr,
  output logic [DW-1:0]     fb_req_wdata,
  input  logic              fb_rsp_valid,
  input  logic [DW-1:0]     fb_rsp_data,
  output logic              buf_we,
  output logic              buf_wsel,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [DW-1:0]     buf_wdata,
  output logic              buf_re,
  output logic [BUF_AW-1:0] buf_src_raddr,
  output logic [BUF_AW-1:0] buf_dst_raddr,
  output logic              rop_expand,
  output logic              rop_src_en,
  output logic              rop_dst_en,
  input  logic [DW-1:0]     rop_result
);

  logic             start;
  blit_mode_t       mode;
  logic [LEN_W-1:0] width;
  logic [LEN_W-1:0] height;
  logic [AW-1:0]    src_base, src_stride, dst_base, dst_stride;
  logic [AW-1:0]    src_line, dst_line;
  logic [BUF_AW-1:0] bmp_line;
  logic             last_line;
  logic             line_init, line_step;

  blit_regs #(.AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .start      (start),
    .mode       (mode),
    .width      (width),
    .height     (height),
    .src_base   (src_base),
    .src_stride (src_stride),
    .dst_base   (dst_base),
    .dst_stride (dst_stride)
  );

  blit_line_addr #(.AW(AW), .LEN_W(LEN_W), .BUF_AW(BUF_AW)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .init       (line_init),
    .step       (line_step),
    .width      (width),
    .height     (height),
    .src_base   (src_base),
    .src_stride (src_stride),
    .dst_base   (dst_base),
    .dst_stride (dst_stride),
    .src_line   (src_line),
    .dst_line   (dst_line),
    .bmp_line   (bmp_line),
    .last_line  (last_line)
  );

  blit_fsm #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .BUF_AW(BUF_AW)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .src_kind      (mode.src),
    .dst_kind      (mode.dst),
    .width         (width),
    .height        (height),
    .src_line      (src_line),
    .dst_line      (dst_line),
    .bmp_line      (bmp_line),
    .last_line     (last_line),
    .fb_req_ready  (fb_req_ready),
    .fb_rsp_valid  (fb_rsp_valid),
    .fb_rsp_data   (fb_rsp_data),
    .rop_result    (rop_result),
    .busy          (busy),
    .line_init     (line_init),
    .line_step     (line_step),
    .fb_req_valid  (fb_req_valid),
    .fb_req_we     (fb_req_we),
    .fb_req_addr   (fb_req_addr),
    .fb_req_wdata  (fb_req_wdata),
    .buf_we        (buf_we),
    .buf_wsel      (buf_wsel),
    .buf_waddr     (buf_waddr),
    .buf_wdata     (buf_wdata),
    .buf_re        (buf_re),
    .buf_src_raddr (buf_src_raddr),
    .buf_dst_raddr (buf_dst_raddr)
  );

  assign rop_expand = mode.expand;
  assign rop_src_en = kind_used(mode.src);
  assign rop_dst_en = kind_used(mode.dst);

endmodule

// File: rtl/blit_line_seq_chk.sv
`timescale 1ns/1ps
module blit_line_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          fb_req_valid,
  input logic          fb_req_ready,
  input logic          fb_req_we,
  input logic [AW-1:0] fb_req_addr,
  input logic [DW-1:0] fb_req_wdata,
  input logic          buf_we,
  input logic          buf_re,
  input logic          rop_expand,
  input logic          rop_src_en,
  input logic          rop_dst_en
);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    fb_req_valid && !fb_req_ready |=> fb_req_valid && $stable(fb_req_addr)
      && $stable(fb_req_we) && $stable(fb_req_wdata));

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fb_req_valid);

  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(rop_expand) && $stable(rop_src_en) && $stable(rop_dst_en));

  assert_load_before_read_R7: assert property (@(posedge clk) disable iff (rst)
    !(buf_we && buf_re));

  assert_fall_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !fb_req_valid && !buf_re);

endmodule

bind blit_line_seq blit_line_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .fb_req_valid (fb_req_valid),
  .fb_req_ready (fb_req_ready),
  .fb_req_we    (fb_req_we),
  .fb_req_addr  (fb_req_addr),
  .fb_req_wdata (fb_req_wdata),
  .buf_we       (buf_we),
  .buf_re       (buf_re),
  .rop_expand   (rop_expand),
  .rop_src_en   (rop_src_en),
  .rop_dst_en   (rop_dst_en)
);

// File: tb/sim_blit_line_seq.sv
`timescale 1ns/1ps
module sim_blit_line_seq;
  localparam int AW = 32, DW = 8, LEN_W = 16, BUF_AW = 8;
  localparam int DEPTH = 1 << BUF_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic              busy, fb_req_valid, fb_req_we;
  logic              fb_req_ready = 1'b0;
  logic [AW-1:0]     fb_req_addr;
  logic [DW-1:0]     fb_req_wdata;
  logic              fb_rsp_valid = 1'b0;
  logic [DW-1:0]     fb_rsp_data = '0;
  logic              buf_we, buf_wsel, buf_re;
  logic [BUF_AW-1:0] buf_waddr, buf_src_raddr, buf_dst_raddr;
  logic [DW-1:0]     buf_wdata;
  logic              rop_expand, rop_src_en, rop_dst_en;
  logic [DW-1:0]     rop_result;

  blit_line_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .BUF_AW(BUF_AW)) u0 (.*);

  function automatic logic [7:0] fb_byte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] dpre(int i);
    return 8'hC3 ^ 8'(i * 7);
  endfunction

  // line buffer model: one-cycle read latency
  logic [7:0] src_arr [DEPTH];
  logic [7:0] dst_arr [DEPTH];
  logic [7:0] src_q = '0, dst_q = '0;
  always @(posedge clk) begin
    if (buf_we) begin
      if (buf_wsel) dst_arr[buf_waddr] <= buf_wdata;
      else          src_arr[buf_waddr] <= buf_wdata;
    end
    if (buf_re) begin
      src_q <= src_arr[buf_src_raddr];
      dst_q <= dst_arr[buf_dst_raddr];
    end
  end
  assign rop_result = (rop_src_en ? src_q : 8'h00) ^ (rop_dst_en ? {dst_q[3:0], dst_q[7:4]} : 8'h00)
                      ^ (rop_expand ? 8'hFF : 8'h00);

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [7:0]  data;
    string       tag;
  } beat_t;
  beat_t exp_q[$];

  int n_cmp = 0, n_bad = 0, cyc = 0, last_acc = 0;
  bit pend = 0, stall_prev = 0, prev_we = 0, done = 0;
  logic [7:0]  pend_data = '0, prev_data = '0;
  logic [31:0] prev_addr = '0;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: frame-buffer responder and scoreboard
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      check(0, "R9", "watchdog expired", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    if (!rst) begin
      fb_rsp_valid = pend;
      fb_rsp_data  = pend_data;
      pend = 0;
      if (stall_prev)
        check(fb_req_valid && fb_req_addr == prev_addr && fb_req_we == prev_we &&
              fb_req_wdata == prev_data, "R8", "request held during stall",
              fb_req_addr, prev_addr);
      fb_req_ready = ($urandom % 4) != 0;
      if (fb_req_valid && fb_req_ready) begin
        last_acc = cyc;
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected request addr", fb_req_addr, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(fb_req_we == e.we && fb_req_addr == e.addr, e.tag, "request dir/addr",
                {fb_req_we, fb_req_addr}, {e.we, e.addr});
          if (e.we) check(fb_req_wdata == e.data, e.tag, "write data", fb_req_wdata, e.data);
        end
        if (!fb_req_we) begin
          pend = 1;
          pend_data = fb_byte(fb_req_addr);
        end
      end
      stall_prev = fb_req_valid && !fb_req_ready;
      prev_addr  = fb_req_addr;
      prev_we    = fb_req_we;
      prev_data  = fb_req_wdata;
    end
  end

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // driver: computes every expected beat from the requirements, then runs the transfer
  task automatic run_blit(int sk, int dk, bit ex, int w, int h, int sb, int ss, int db, int ds,
                          bit poke);
    bit s_en, d_en;
    int waited;
    s_en = (sk == 1 || sk == 2);
    d_en = (dk == 1 || dk == 2);
    if (dk == 2) for (int i = 0; i < DEPTH; i++) dst_arr[i] = dpre(i);
    if (sk == 2)
      for (int k = 0; k < w * h; k++) exp_q.push_back('{0, 32'(sb + k), 8'h00, "R6"});
    for (int y = 0; y < h; y++) begin
      if (sk == 1) for (int xx = 0; xx < w; xx++)
        exp_q.push_back('{0, 32'(sb + y * ss + xx), 8'h00, "R4"});
      if (dk == 1) for (int xx = 0; xx < w; xx++)
        exp_q.push_back('{0, 32'(db + y * ds + xx), 8'h00, "R5"});
      for (int xx = 0; xx < w; xx++) begin
        logic [7:0] s, d, r;
        s = (sk == 1) ? fb_byte(32'(sb + y * ss + xx)) : (sk == 2) ? fb_byte(32'(sb + y * w + xx)) : 8'h00;
        d = (dk == 1) ? fb_byte(32'(db + y * ds + xx)) : (dk == 2) ? dpre(xx) : 8'h00;
        r = (s_en ? s : 8'h00) ^ (d_en ? {d[3:0], d[7:4]} : 8'h00) ^ (ex ? 8'hFF : 8'h00);
        exp_q.push_back('{1, 32'(db + y * ds + xx), r, "R7"});
      end
    end
    reg_wr(3'd1, 32'(w));
    reg_wr(3'd2, 32'(h));
    reg_wr(3'd3, 32'(sb));
    reg_wr(3'd4, 32'(ss));
    reg_wr(3'd5, 32'(db));
    reg_wr(3'd6, 32'(ds));
    reg_wr(3'd0, {27'd0, ex, 2'(dk), 2'(sk)});
    waited = 0;
    while (!busy && waited < 4) begin @(negedge clk); waited++; end
    check(busy == 1'b1, "R2", "busy after mode write", busy, 1);
    check(rop_expand == ex && rop_src_en == s_en && rop_dst_en == d_en, "R3",
          "mode fields to combine stage", {rop_expand, rop_src_en, rop_dst_en}, {ex, s_en, d_en});
    if (!s_en || !d_en) check((rop_src_en == s_en) && (rop_dst_en == d_en), "R12",
          "absent operand enable low", {rop_src_en, rop_dst_en}, {s_en, d_en});
    if (poke) begin
      reg_wr(3'd1, 32'(w + 3));
      reg_wr(3'd0, 32'h0000_0011);
    end
    waited = 0;
    while (busy && waited < 20000) begin @(negedge clk); waited++; end
    check(exp_q.size() == 0, "R9", "beats left at busy fall", exp_q.size(), 0);
    check(cyc - last_acc <= 3, "R9", "busy fall delay", cyc - last_acc, 3);
    exp_q.delete();
    repeat (8) @(negedge clk);
    check(busy == 1'b0, "R10", "no restart after ignored writes", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin src_arr[i] = 8'h00; dst_arr[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && fb_req_valid == 0 && buf_we == 0 && buf_re == 0, "R1",
          "reset state", {busy, fb_req_valid, buf_we, buf_re}, 0);
    // R4 R5 R7: both operands from the frame buffer
    run_blit(1, 1, 0, 6, 3, 'h1000, 16, 'h4000, 32, 0);
    // R6: bitmap source in local buffer, no destination operand
    run_blit(2, 0, 1, 4, 3, 'h2200, 0, 'h6000, 20, 0);
    // R12: no source, destination from local buffer
    run_blit(0, 2, 0, 5, 2, 0, 0, 'h7100, 64, 0);
    // R10: register writes while busy are ignored
    run_blit(1, 0, 1, 3, 4, 'h3300, 8, 'h8000, 12, 1);
    // both frame buffer with expansion, single line
    run_blit(1, 1, 1, 7, 1, 'h0A00, 0, 'h0C00, 0, 0);
    // R11: zero height makes no request
    reg_wr(3'd2, 32'd0);
    reg_wr(3'd0, 32'h0000_0005);
    begin
      bit seen;
      seen = 0;
      repeat (10) begin @(negedge clk); if (busy || fb_req_valid) seen = 1; end
      check(!seen, "R11", "zero height stays idle", seen, 0);
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule